// File: doc/BRIEF.md
# Banked Histogram Counter with Merge Readout

This block keeps a histogram of bin indices that arrive at up to one per clock. Each accepted index adds one to a counter for that bin. The counters live in several small memories, and every memory update is a read followed by a write. If all updates went to one memory, an update would have to wait for the previous one to the same memory. To avoid that wait, successive updates are dealt out in turn across four independent counter banks. A bank therefore normally sees a new update only every fourth update. A row-start flag sent with an update forces that update back to the first bank, so that each row of work begins at a fixed bank.

Software-side sequencing is simple. A clear command first zeroes every bin of every bank, one bin address per cycle, and a done pulse marks the final cycle. Indices are then streamed in. A merge request then walks the bins in ascending order, adds the four bank counts of each bin, and streams the totals out with a valid flag and a last marker. An index offered while a clear or a merge is running is dropped and flagged on an error output in the same cycle.

Top module: `hist_accum`

## Requirements
- R1: While reset is asserted and after its release, res_valid, res_last and clr_done are low, and upd_err is low whenever upd_valid is low.
- R2: Accepted updates go to banks 0, 1, 2, 3, 0, ... in turn; an accepted update with row_start high goes to bank 0, and the next accepted update without row_start goes to bank 1.
- R3: Each accepted update adds exactly one to one counter of one bank. The merged total reported for a bin equals the number of updates accepted with that index since the last clear, modulo 2^48.
- R4: Updates accepted on every cycle, including a single index repeated on consecutive cycles and row_start high on consecutive cycles, are all counted with no stall and no loss.
- R5: clr_req sampled while idle zeroes all 32 bins of all banks during the next 32 cycles. clr_done is high for exactly the last of those cycles. The block is idle again in the following cycle.
- R6: merge_req sampled while idle in cycle m yields bin k's total (the sum over the four banks) on res_count with res_valid high and res_bin = k in cycle m+2+k, for k = 0..31. There is one result per cycle, and res_valid is low otherwise.
- R7: res_last is high exactly on the result for bin 31.
- R8: An update offered while a clear or merge is running changes no counter, and upd_err is high in that same cycle; upd_err is low in all other cycles.
- R9: An update accepted in the same cycle in which merge_req is sampled is included in that merge's totals.
- R10: clr_req or merge_req arriving while a clear or merge is running is ignored. When both arrive together while idle, the clear is performed and the merge request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | An index is offered this cycle |
| upd_bin | input | 5 | Bin index to count |
| row_start | input | 1 | This update begins a row; forces bank 0 |
| clr_req | input | 1 | Start zeroing all counters |
| clr_done | output | 1 | High in the final cycle of a clear |
| merge_req | input | 1 | Start the merged readout |
| res_valid | output | 1 | A merged total is presented |
| res_bin | output | 5 | Bin of the presented total |
| res_count | output | 48 | Sum of the four bank counts for res_bin |
| res_last | output | 1 | The presented total is the final bin |
| upd_err | output | 1 | An update was offered while busy and dropped |

## Verification
The hardest situation to reach from the ports is a single bank receiving updates on two successive cycles. In that case, the second read of a counter overlaps the first update's write-back. Plain rotation never produces this case. Only row_start held high across consecutive updates does, and more so when those updates carry one index. The stimulus therefore drives rows of length one, back to back, on one bin and on alternating bins. It also mixes random row_start pulses into a dense random stream. Merges then expose every lost or doubled count. A second hard corner is an update accepted in the very cycle a merge or a clear starts. The bench drives requests and updates together for this case.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    HM_IDLE  = 2'd0,
    HM_CLEAR = 2'd1,
    HM_MERGE = 2'd2
  } hist_mode_e;
endpackage

// File: rtl/hist_bank.sv
// One counter bank: registered read port, write port, and a bypass that
// returns the value being written when both ports hit one address.
module hist_bank #(
  parameter int NBINS = 32,
  parameter int CNT_W = 48,
  parameter int AW    = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] mem [NBINS];
  logic [CNT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) begin
      if (wr_en && (wr_addr == rd_addr)) rd_q <= wr_data;
      else                               rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/hist_rotor.sv
// Bank selector: deals accepted updates round-robin, restart forces bank 0.
module hist_rotor #(
  parameter int NBANKS = 4,
  parameter int BW     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          restart,
  output logic [BW-1:0] bank
);
  logic [BW-1:0] sel_q;

  assign bank = restart ? '0 : sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (step) begin
      if (bank == BW'(NBANKS - 1)) sel_q <= '0;
      else                         sel_q <= bank + BW'(1);
    end
  end
endmodule

// File: rtl/hist_seq.sv
// Mode sequencer: idle, clear walk and merge walk over all bin addresses.
module hist_seq
  import hist_pkg::*;
#(
  parameter int NBINS = 32,
  parameter int AW    = $clog2(NBINS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_req,
  input  logic          merge_req,
  output hist_mode_e    mode,
  output logic [AW-1:0] addr,
  output logic          last
);
  assign last = (addr == AW'(NBINS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= HM_IDLE;
      addr <= '0;
    end else begin
      case (mode)
        HM_IDLE: begin
          addr <= '0;
          if (clr_req)        mode <= HM_CLEAR;
          else if (merge_req) mode <= HM_MERGE;
        end
        default: begin
          if (last) begin
            mode <= HM_IDLE;
            addr <= '0;
          end else begin
            addr <= addr + AW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int NBINS  = 32,
  parameter int CNT_W  = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_valid,
  input  logic [$clog2(NBINS)-1:0] upd_bin,
  input  logic                     row_start,
  input  logic                     clr_req,
  output logic                     clr_done,
  input  logic                     merge_req,
  output logic                     res_valid,
  output logic [$clog2(NBINS)-1:0] res_bin,
  output logic [CNT_W-1:0]         res_count,
  output logic                     res_last,
  output logic                     upd_err
);
  localparam int AW = $clog2(NBINS);
  localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] fold(input logic [NBANKS-1:0][CNT_W-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NBANKS; i++) s = s + v[i];
    return s;
  endfunction

  hist_mode_e mode;
  logic [AW-1:0] seq_addr;
  logic seq_last;

  hist_seq #(.NBINS(NBINS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .merge_req(merge_req),
    .mode(mode), .addr(seq_addr), .last(seq_last)
  );

  logic idle, clearing, merging;
  assign idle     = (mode == HM_IDLE);
  assign clearing = (mode == HM_CLEAR);
  assign merging  = (mode == HM_MERGE);

  // accepted update and its bank (named events for the checker)
  logic          acc;
  logic [BW-1:0] acc_bank;
  assign acc = upd_valid && idle;

  hist_rotor #(.NBANKS(NBANKS), .BW(BW)) u_rot (
    .clk(clk), .rst_n(rst_n), .step(acc), .restart(row_start), .bank(acc_bank)
  );

  // write-back stage of the read-increment-write
  logic          s1_vld;
  logic [BW-1:0] s1_bank;
  logic [AW-1:0] s1_bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_bank <= '0;
      s1_bin  <= '0;
    end else begin
      s1_vld  <= acc;
      s1_bank <= acc_bank;
      s1_bin  <= upd_bin;
    end
  end

  logic [NBANKS-1:0][CNT_W-1:0] rd_data;
  logic [NBANKS-1:0]            bank_wr_vec;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic          rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [CNT_W-1:0] wr_data;

    assign bank_wr_vec[b] = s1_vld && (s1_bank == BW'(b));
    assign rd_en   = (acc && (acc_bank == BW'(b))) || merging;
    assign rd_addr = merging ? seq_addr : upd_bin;
    assign wr_en   = clearing || bank_wr_vec[b];
    assign wr_addr = clearing ? seq_addr : s1_bin;
    assign wr_data = clearing ? '0 : bump(rd_data[b]);

    hist_bank #(.NBINS(NBINS), .CNT_W(CNT_W), .AW(AW)) u_bank (
      .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data[b])
    );
  end

  // merge output stage
  logic          m_vld;
  logic [AW-1:0] m_bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= 1'b0;
      m_bin <= '0;
    end else begin
      m_vld <= merging;
      m_bin <= seq_addr;
    end
  end

  assign res_valid = m_vld;
  assign res_bin   = m_bin;
  assign res_count = fold(rd_data);
  assign res_last  = m_vld && (m_bin == AW'(NBINS - 1));
  assign clr_done  = clearing && seq_last;
  assign upd_err   = upd_valid && !idle;
endmodule

// File: rtl/hist_accum_chk.sv
module hist_accum_chk #(
  parameter int NBANKS = 4,
  parameter int NBINS  = 32,
  parameter int AW     = $clog2(NBINS),
  parameter int BW     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc,
  input logic [BW-1:0]     acc_bank,
  input logic              row_start,
  input logic              upd_valid,
  input logic              upd_err,
  input logic              busy,
  input logic [NBANKS-1:0] bank_wr_vec,
  input logic              res_valid,
  input logic [AW-1:0]     res_bin,
  input logic              res_last,
  input logic              clr_done
);
  assert_row_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && row_start |-> acc_bank == '0);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !row_start && $past(acc) && ($past(acc_bank) != BW'(NBANKS - 1))
      |-> acc_bank == $past(acc_bank) + BW'(1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !row_start && $past(acc) && ($past(acc_bank) == BW'(NBANKS - 1))
      |-> acc_bank == '0);

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr_vec));

  assert_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && busy |-> upd_err && !acc);

  assert_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && busy) |-> !upd_err);

  assert_last_bin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |-> res_valid && res_bin == AW'(NBINS - 1));

  assert_merge_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_last |=> res_valid && res_bin == $past(res_bin) + AW'(1));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !clr_done);
endmodule

bind hist_accum hist_accum_chk #(.NBANKS(NBANKS), .NBINS(NBINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .acc_bank(acc_bank),
  .row_start(row_start), .upd_valid(upd_valid), .upd_err(upd_err),
  .busy(!idle), .bank_wr_vec(bank_wr_vec), .res_valid(res_valid),
  .res_bin(res_bin), .res_last(res_last), .clr_done(clr_done)
);

// File: tb/sim_hist_accum.sv
`timescale 1ns/1ps
module sim_hist_accum;
  localparam int NBINS = 32;
  localparam int AW    = 5;
  localparam int CW    = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic [AW-1:0] upd_bin = '0;
  logic row_start = 1'b0;
  logic clr_req = 1'b0;
  logic merge_req = 1'b0;
  logic clr_done, res_valid, res_last, upd_err;
  logic [AW-1:0] res_bin;
  logic [CW-1:0] res_count;

  always #2.5 clk = ~clk;

  hist_accum u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_bin(upd_bin),
    .row_start(row_start), .clr_req(clr_req), .clr_done(clr_done),
    .merge_req(merge_req), .res_valid(res_valid), .res_bin(res_bin),
    .res_count(res_count), .res_last(res_last), .upd_err(upd_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R3";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 clearing, 2 merging
  int     m_mode = 0;
  int     m_idx  = 0;
  longint m_cnt [NBINS];
  bit     e_rv = 0;
  int     e_bin = 0;
  longint e_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_idx = 0; e_rv = 0;
    end else if (!finished) begin
      chk(upd_err == (upd_valid && m_mode != 0), "R8 upd_err", upd_err, upd_valid && m_mode != 0);
      chk(clr_done == (m_mode == 1 && m_idx == NBINS - 1), "R5 clr_done", clr_done,
          m_mode == 1 && m_idx == NBINS - 1);
      chk(res_valid == e_rv, "R6 res_valid", res_valid, e_rv);
      chk(res_last == (e_rv && e_bin == NBINS - 1), "R7 res_last", res_last,
          e_rv && e_bin == NBINS - 1);
      if (e_rv) begin
        chk(res_bin == e_bin, "R6 res_bin", res_bin, e_bin);
        chk(res_count == e_cnt[CW-1:0], {"R3 count ", tag}, res_count, e_cnt);
      end
      // advance to the next cycle
      e_rv = (m_mode == 2);
      if (m_mode == 2) begin
        e_bin = m_idx;
        e_cnt = m_cnt[m_idx];
      end
      if (m_mode == 0 && upd_valid) m_cnt[upd_bin] = m_cnt[upd_bin] + 1;
      case (m_mode)
        0: begin
          m_idx = 0;
          if (clr_req) m_mode = 1;
          else if (merge_req) m_mode = 2;
        end
        default: begin
          if (m_mode == 1) m_cnt[m_idx] = 0;
          if (m_idx == NBINS - 1) begin m_mode = 0; m_idx = 0; end
          else m_idx = m_idx + 1;
        end
      endcase
    end
  end

  task automatic cyc(input bit v, input int b, input bit rs, input bit cr, input bit mr);
    upd_valid = v; upd_bin = b[AW-1:0]; row_start = rs; clr_req = cr; merge_req = mr;
    @(posedge clk); #1;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NBINS; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    chk(res_last == 0, "R1 res_last", res_last, 0);
    chk(clr_done == 0, "R1 clr_done", clr_done, 0);
    chk(upd_err == 0, "R1 upd_err", upd_err, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(res_valid == 0 && clr_done == 0, "R1 after release", res_valid, 0);

    // R5 clear, with R8 updates and R10 merge request during the clear
    tag = "R5";
    cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc(1, i, 0, 0, 1);
    idle_n(30);
    cyc(0, 0, 0, 0, 1);
    idle_n(35);

    // R4: same bin on every cycle
    tag = "R4";
    for (int i = 0; i < 20; i++) cyc(1, 3, 0, 0, 0);
    // R4/R2: rows of length one back to back, same bin then alternating
    for (int i = 0; i < 6; i++) cyc(1, 7, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, (i % 2) ? 8 : 9, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 10, (i == 2), 0, 0);
    // R2: dense random stream with scattered row starts
    begin
      int lf = 32'h1ACE;
      for (int i = 0; i < 300; i++) begin
        lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
        cyc((lf & 7) != 0, (lf >> 3) & 31, ((lf >> 8) & 7) == 0, 0, 0);
      end
    end
    // R9: update in the cycle the merge is requested
    tag = "R9";
    cyc(1, 9, 0, 0, 1);
    // R8/R10: updates and clear request during the merge
    for (int i = 0; i < 3; i++) cyc(1, 9, 0, 1, 0);
    idle_n(35);

    // R10: both requests together -> clear wins
    tag = "R10";
    cyc(1, 4, 0, 1, 1);
    idle_n(33);
    for (int i = 0; i < 8; i++) cyc(1, 31 - i, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    idle_n(36);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      summary();
    end
  end
endmodule